// File: doc/BRIEF.md
# Programmable Interval Timer with Underflow Interrupt

The block is a 16-bit interval timer reached over a plain 32-bit register bus: an address, a write enable, write data and combinational read data. A power-of-two prescaler sets the counting rate. The counter runs either downward toward zero, reloading from a period register each time it passes zero, or upward to the period value, wrapping to zero. In one-shot mode the timer halts after the first wrap. Software starts and stops the timer with command strobes and may load the counter at any time.

Two event flags record wraps. Bit 1 records underflow and bit 0 records overflow. Software sets flags through a set alias and clears them through a clear alias. An enable mask qualifies the flags, and the interrupt line is high while any enabled flag is set. A typical use is a periodic tick from down mode with the reload value as the period, or a single delay from one-shot mode.

Top module: `ivtimer`

## Requirements
- R1: After reset the timer is stopped, the interrupt line is low, and every register reads zero except the period register, which reads 0xffff.
- R2: The control word at offset 0x00 reads back as written. It holds the prescaler code in bits 27:24, the clock-source field in bits 17:16, the one-shot bit in bit 4 and the count mode in bits 1:0. Offsets 0x04, 0x14 and 0x18 read zero, and so does every unmapped offset.
- R3: A write to offset 0x04 with bit 0 set starts the timer, and with bit 1 set stops it. Stop wins when both are set. Every start clears the prescaler phase.
- R4: A write to the counter at offset 0x24 takes effect at the next clock edge, whether the timer is running or not, and overrides any count step in that cycle. A stopped counter holds its value. The counter reads back at 0x24 in bits 15:0.
- R5: With prescaler code n, a running timer takes one count step every 2^n clocks. The first step comes 2^n clocks after the start edge. Codes above 10 behave as code 10.
- R6: In down mode (mode field 1), each step decrements the counter. A step taken at zero instead loads the period register (offset 0x1c, bits 15:0) and sets flag bit 1.
- R7: In every other mode value, each step increments the counter. A step taken when the counter equals the period value instead loads zero and sets flag bit 0.
- R8: With the one-shot bit set, a wrap step reloads as in R6 or R7 and then stops the timer.
- R9: The flags read at offset 0x10. A 1 written to a bit at offset 0x14 sets that flag, and a 1 written at offset 0x18 clears it. Writes to 0x10 are ignored. A hardware set in the same cycle as a software clear leaves the flag set.
- R10: The enable mask is at offset 0x0c, bits 1:0. The interrupt line is high exactly while some flag bit and its enable bit are both 1, and it follows them in the same cycle.
- R11: The clock-source field is only stored. Its value does not change the count rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte offset of the register access |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt request, level |

## Verification
If the prescaler phase is wrong, the first wrap after a start moves by whole clocks. The interrupt edge then lands away from the cycle 1 + (count + 1)·2^n, so one measured start exposes it. A wrong counter or run state shows on the very next counter read, because the bench compares the read data against its own model on every clock. A flag that is wrongly set or cleared shows on the interrupt line in the same cycle whenever its enable bit is set.

// File: rtl/ivtimer_pkg.sv
`timescale 1ns/1ps
package ivtimer_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned FLAG_W = 2;
    localparam int unsigned FLAG_OVF = 0;
    localparam int unsigned FLAG_UNF = 1;

    // register byte offsets
    localparam int unsigned OFS_CTRL = 'h00;
    localparam int unsigned OFS_CMD  = 'h04;
    localparam int unsigned OFS_IEN  = 'h0c;
    localparam int unsigned OFS_FLAG = 'h10;
    localparam int unsigned OFS_FSET = 'h14;
    localparam int unsigned OFS_FCLR = 'h18;
    localparam int unsigned OFS_TOP  = 'h1c;
    localparam int unsigned OFS_CNT  = 'h24;

    // control word field positions
    localparam int unsigned CTRL_PRESC_LSB  = 24;
    localparam int unsigned CTRL_CLKSEL_LSB = 16;
    localparam int unsigned CTRL_OS_BIT     = 4;
    localparam int unsigned CTRL_MODE_LSB   = 0;
    localparam int unsigned CMD_START_BIT   = 0;
    localparam int unsigned CMD_STOP_BIT    = 1;

    localparam logic [1:0] MODE_DOWN = 2'd1;

    typedef struct packed {
        logic [3:0] presc;
        logic [1:0] clksel;
        logic       oneshot;
        logic [1:0] mode;
    } ctrl_t;
endpackage

// File: rtl/ivtimer_regs.sv
`timescale 1ns/1ps
module ivtimer_regs
    import ivtimer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [3:0]        presc_o,
    output logic              oneshot_o,
    output logic              down_o,
    output logic [FLAG_W-1:0] ien_o,
    output logic [CNT_W-1:0]  top_o,
    output logic              start_o,
    output logic              stop_o,
    output logic              cnt_wr_o,
    output logic [CNT_W-1:0]  cnt_wdata_o,
    output logic [FLAG_W-1:0] fset_o,
    output logic [FLAG_W-1:0] fclr_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [FLAG_W-1:0] ien;
        logic [CNT_W-1:0]  top;
    } regs_t;

    localparam regs_t RST_VAL = '{ctrl: '0, ien: '0, top: '1};

    regs_t st_q, st_d;

    function automatic logic wr_hit(input int unsigned ofs);
        return bus_we_i && (bus_addr_i == ADDR_W'(ofs));
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_hit(OFS_CTRL)) begin
            st_d.ctrl.presc   = bus_wdata_i[CTRL_PRESC_LSB +: 4];
            st_d.ctrl.clksel  = bus_wdata_i[CTRL_CLKSEL_LSB +: 2];
            st_d.ctrl.oneshot = bus_wdata_i[CTRL_OS_BIT];
            st_d.ctrl.mode    = bus_wdata_i[CTRL_MODE_LSB +: 2];
        end
        if (wr_hit(OFS_IEN)) st_d.ien = bus_wdata_i[FLAG_W-1:0];
        if (wr_hit(OFS_TOP)) st_d.top = bus_wdata_i[CNT_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= RST_VAL;
        else         st_q <= st_d;
    end

    assign presc_o     = st_q.ctrl.presc;
    assign oneshot_o   = st_q.ctrl.oneshot;
    assign down_o      = (st_q.ctrl.mode == MODE_DOWN);
    assign ien_o       = st_q.ien;
    assign top_o       = st_q.top;
    assign start_o     = wr_hit(OFS_CMD) && bus_wdata_i[CMD_START_BIT];
    assign stop_o      = wr_hit(OFS_CMD) && bus_wdata_i[CMD_STOP_BIT];
    assign cnt_wr_o    = wr_hit(OFS_CNT);
    assign cnt_wdata_o = bus_wdata_i[CNT_W-1:0];
    assign fset_o      = wr_hit(OFS_FSET) ? bus_wdata_i[FLAG_W-1:0] : '0;
    assign fclr_o      = wr_hit(OFS_FCLR) ? bus_wdata_i[FLAG_W-1:0] : '0;

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_W'(OFS_CTRL): begin
                bus_rdata_o[CTRL_PRESC_LSB +: 4]  = st_q.ctrl.presc;
                bus_rdata_o[CTRL_CLKSEL_LSB +: 2] = st_q.ctrl.clksel;
                bus_rdata_o[CTRL_OS_BIT]          = st_q.ctrl.oneshot;
                bus_rdata_o[CTRL_MODE_LSB +: 2]   = st_q.ctrl.mode;
            end
            ADDR_W'(OFS_IEN):  bus_rdata_o[FLAG_W-1:0] = st_q.ien;
            ADDR_W'(OFS_FLAG): bus_rdata_o[FLAG_W-1:0] = flags_i;
            ADDR_W'(OFS_TOP):  bus_rdata_o[CNT_W-1:0]  = st_q.top;
            ADDR_W'(OFS_CNT):  bus_rdata_o[CNT_W-1:0]  = cnt_i;
            default:           bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/ivtimer_prescale.sv
`timescale 1ns/1ps
module ivtimer_prescale #(
    parameter int PRE_MAX = 10
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic       restart_i,
    input  logic [3:0] code_i,
    output logic       tick_o
);
    localparam int PRE_W = PRE_MAX;

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_t;

    pre_t st_q, st_d;
    int               code_eff;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;
    logic             unused_span_msb;

    always_comb begin
        code_eff = (int'(code_i) > PRE_MAX) ? PRE_MAX : int'(code_i);
        span     = ((PRE_W+1)'(1) << code_eff) - (PRE_W+1)'(1);
        mask     = span[PRE_W-1:0];
        tick_o   = run_i && ((st_q.phase & mask) == mask);
        st_d     = st_q;
        if (restart_i)  st_d.phase = '0;
        else if (run_i) st_d.phase = st_q.phase + PRE_W'(1);
    end

    assign unused_span_msb = span[PRE_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/ivtimer_core.sv
`timescale 1ns/1ps
module ivtimer_core
    import ivtimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              down_i,
    input  logic              oneshot_i,
    input  logic [CNT_W-1:0]  top_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              cnt_wr_i,
    input  logic [CNT_W-1:0]  cnt_wdata_i,
    input  logic [FLAG_W-1:0] fset_i,
    input  logic [FLAG_W-1:0] fclr_i,
    output logic              run_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [FLAG_W-1:0] flags_o
);
    typedef struct packed {
        logic              run;
        logic [CNT_W-1:0]  cnt;
        logic [FLAG_W-1:0] flags;
    } core_t;

    core_t st_q, st_d;
    logic              at_end;
    logic              wrap;
    logic [FLAG_W-1:0] hw_set;

    always_comb begin
        at_end = down_i ? (st_q.cnt == '0) : (st_q.cnt == top_i);
        wrap   = tick_i && at_end;
        hw_set = '0;
        if (wrap) hw_set[down_i ? FLAG_UNF : FLAG_OVF] = 1'b1;

        st_d = st_q;
        if (cnt_wr_i) begin
            st_d.cnt = cnt_wdata_i;
        end else if (tick_i) begin
            if (wrap)        st_d.cnt = down_i ? top_i : '0;
            else if (down_i) st_d.cnt = st_q.cnt - CNT_W'(1);
            else             st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        if (stop_i)                  st_d.run = 1'b0;
        else if (start_i)            st_d.run = 1'b1;
        else if (wrap && oneshot_i)  st_d.run = 1'b0;

        // hardware set is applied last so it beats a software clear
        st_d.flags = ((st_q.flags | fset_i) & ~fclr_i) | hw_set;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign run_o   = st_q.run;
    assign cnt_o   = st_q.cnt;
    assign flags_o = st_q.flags;
endmodule

// File: rtl/ivtimer.sv
`timescale 1ns/1ps
module ivtimer
    import ivtimer_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CNT_W   = 16,
    parameter int PRE_MAX = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);
    logic [3:0]        presc;
    logic              oneshot;
    logic              down;
    logic [FLAG_W-1:0] ien;
    logic [CNT_W-1:0]  top_val;
    logic              start;
    logic              stop;
    logic              cnt_wr;
    logic [CNT_W-1:0]  cnt_wdata;
    logic [FLAG_W-1:0] fset;
    logic [FLAG_W-1:0] fclr;
    logic              run;
    logic              tick;
    logic [CNT_W-1:0]  cnt;
    logic [FLAG_W-1:0] flags;

    ivtimer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_addr_i  (bus_addr_i),
        .bus_we_i    (bus_we_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .cnt_i       (cnt),
        .flags_i     (flags),
        .presc_o     (presc),
        .oneshot_o   (oneshot),
        .down_o      (down),
        .ien_o       (ien),
        .top_o       (top_val),
        .start_o     (start),
        .stop_o      (stop),
        .cnt_wr_o    (cnt_wr),
        .cnt_wdata_o (cnt_wdata),
        .fset_o      (fset),
        .fclr_o      (fclr)
    );

    ivtimer_prescale #(.PRE_MAX(PRE_MAX)) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .restart_i (start),
        .code_i    (presc),
        .tick_o    (tick)
    );

    ivtimer_core #(.CNT_W(CNT_W)) u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick),
        .down_i      (down),
        .oneshot_i   (oneshot),
        .top_i       (top_val),
        .start_i     (start),
        .stop_i      (stop),
        .cnt_wr_i    (cnt_wr),
        .cnt_wdata_i (cnt_wdata),
        .fset_i      (fset),
        .fclr_i      (fclr),
        .run_o       (run),
        .cnt_o       (cnt),
        .flags_o     (flags)
    );

    assign irq_o = |(flags & ien);
endmodule

// File: rtl/ivtimer_chk.sv
`timescale 1ns/1ps
module ivtimer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             run,
    input logic             tick,
    input logic             down,
    input logic             oneshot,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] top_val,
    input logic [1:0]       flags,
    input logic [1:0]       ien,
    input logic             cnt_wr,
    input logic             start,
    input logic             stop,
    input logic [1:0]       fset,
    input logic [1:0]       fclr
);
    assert_stop_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !run);

    assert_start_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> run);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    assert_down_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && down && cnt != '0 && !cnt_wr) |=> (cnt == $past(cnt) - CNT_W'(1)));

    assert_down_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && down && cnt == '0 && !cnt_wr) |=> (cnt == $past(top_val) && flags[1]));

    assert_up_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !down && cnt == top_val && !cnt_wr) |=> (cnt == '0 && flags[0]));

    assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && oneshot && !start && (down ? (cnt == '0) : (cnt == top_val))) |=> !run);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fclr[1] && !fset[1] && !(tick && down && cnt == '0)) |=> !flags[1]);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 2'b00) |-> !irq_o);
endmodule

bind ivtimer ivtimer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .irq_o   (irq_o),
    .run     (run),
    .tick    (tick),
    .down    (down),
    .oneshot (oneshot),
    .cnt     (cnt),
    .top_val (top_val),
    .flags   (flags),
    .ien     (ien),
    .cnt_wr  (cnt_wr),
    .start   (start),
    .stop    (stop),
    .fset    (fset),
    .fclr    (fclr)
);

// File: tb/ivtimer_tb_top.sv
`timescale 1ns/1ps
module ivtimer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h24;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ivtimer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_addr_i  (bus_addr),
        .bus_we_i    (bus_we),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    // behavioural reference model
    logic [3:0]  m_presc = '0;
    logic [1:0]  m_clksel = '0;
    logic        m_os = 1'b0;
    logic [1:0]  m_mode = '0;
    logic [1:0]  m_ien = '0;
    logic [15:0] m_top = 16'hffff;
    logic [15:0] m_cnt = '0;
    logic [1:0]  m_flags = '0;
    logic        m_run = 1'b0;
    logic [9:0]  m_pre = '0;
    int          t_code, t_mask, t_wa;
    bit          t_tick, t_down, t_wrap, t_start, t_stop;
    logic [15:0] n_cnt;
    logic [9:0]  n_pre;
    logic        n_run;
    logic [1:0]  t_hw, t_set, t_clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_presc = '0; m_clksel = '0; m_os = 1'b0; m_mode = '0; m_ien = '0;
            m_top = 16'hffff; m_cnt = '0; m_flags = '0; m_run = 1'b0; m_pre = '0;
        end else begin
            t_code  = (m_presc > 4'd10) ? 10 : int'(m_presc);
            t_mask  = (1 << t_code) - 1;
            t_tick  = m_run && ((int'(m_pre) & t_mask) == t_mask);
            t_down  = (m_mode == 2'd1);
            t_wrap  = t_tick && (t_down ? (m_cnt == 16'd0) : (m_cnt == m_top));
            t_wa    = bus_we ? int'(bus_addr) : -1;
            t_start = (t_wa == 'h04) && bus_wdata[0];
            t_stop  = (t_wa == 'h04) && bus_wdata[1];
            n_cnt = m_cnt;
            if (t_wa == 'h24) n_cnt = bus_wdata[15:0];
            else if (t_tick) begin
                if (t_wrap)      n_cnt = t_down ? m_top : 16'd0;
                else if (t_down) n_cnt = m_cnt - 16'd1;
                else             n_cnt = m_cnt + 16'd1;
            end
            n_run = t_stop ? 1'b0 : t_start ? 1'b1 : (t_wrap && m_os) ? 1'b0 : m_run;
            n_pre = t_start ? 10'd0 : m_run ? m_pre + 10'd1 : m_pre;
            t_hw  = t_wrap ? (t_down ? 2'b10 : 2'b01) : 2'b00;
            t_set = (t_wa == 'h14) ? bus_wdata[1:0] : 2'b00;
            t_clr = (t_wa == 'h18) ? bus_wdata[1:0] : 2'b00;
            if (t_wa == 'h00) begin
                m_presc = bus_wdata[27:24]; m_clksel = bus_wdata[17:16];
                m_os = bus_wdata[4]; m_mode = bus_wdata[1:0];
            end
            if (t_wa == 'h0c) m_ien = bus_wdata[1:0];
            if (t_wa == 'h1c) m_top = bus_wdata[15:0];
            m_flags = ((m_flags | t_set) & ~t_clr) | t_hw;
            m_cnt = n_cnt; m_run = n_run; m_pre = n_pre;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return {4'b0, m_presc, 6'b0, m_clksel, 11'b0, m_os, 2'b0, m_mode};
            8'h0c: return {30'b0, m_ien};
            8'h10: return {30'b0, m_flags};
            8'h1c: return {16'b0, m_top};
            8'h24: return {16'b0, m_cnt};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h0c: return "R10";
            8'h10: return "R9";
            8'h1c: return "R6";
            8'h24: return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 irq", {31'b0, irq}, {31'b0, |(m_flags & m_ien)});
            chk(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0; bus_addr = 8'h24; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    // start the timer and count clocks until the interrupt line is seen
    task automatic start_measure(input int limit, output int cyc);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h1;
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            if (cyc == 1) begin
                #1; bus_we = 1'b0; bus_addr = 8'h24; bus_wdata = '0;
            end
            @(negedge clk);
        end while (!irq && cyc < limit);
    endtask

    task automatic halt_and_clear();
        wr(8'h04, 32'h2);
        wr(8'h18, 32'h3);
    endtask

    function automatic logic [31:0] ctrl_word(input int presc, input int clksel,
                                              input bit os, input int mode);
        return (32'(presc) << 24) | (32'(clksel) << 16) | (32'(os) << 4) | 32'(mode);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int cyc;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h1c, v); chk("R1 top", v, 32'h0000_ffff);
        rd(8'h24, v); chk("R1 cnt", v, 32'h0);
        rd(8'h10, v); chk("R1 flags", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 control readback and zero-reading offsets
        wr(8'h00, ctrl_word(5, 2, 1'b1, 1));
        rd(8'h00, v); chk("R2 ctrl", v, 32'h0502_0011);
        rd(8'h04, v); chk("R2 cmd", v, 32'h0);
        rd(8'h14, v); chk("R2 fset", v, 32'h0);
        rd(8'h08, v); chk("R2 unmapped", v, 32'h0);
        wr(8'h10, 32'h3);
        rd(8'h10, v); chk("R9 flag write ignored", v, 32'h0);

        // R4 load while stopped, then hold
        wr(8'h24, 32'h1234);
        rd(8'h24, v); chk("R4 load", v, 32'h1234);
        repeat (20) @(negedge clk);
        rd(8'h24, v); chk("R4 hold", v, 32'h1234);

        // R6 down-mode period, prescaler code 0
        wr(8'h0c, 32'h2);
        wr(8'h1c, 32'h40);
        wr(8'h00, ctrl_word(0, 0, 1'b0, 1));
        wr(8'h24, 32'd5);
        start_measure(100, cyc); chk("R6 down period", 32'(cyc), 32'd7);
        halt_and_clear();

        // R5 and R11 prescaler code 2 with a clock-source field set
        wr(8'h00, ctrl_word(2, 3, 1'b0, 1));
        wr(8'h24, 32'd5);
        start_measure(200, cyc); chk("R5 R11 code2 period", 32'(cyc), 32'd25);
        halt_and_clear();

        // R5 code above 10 acts as 10
        wr(8'h00, ctrl_word(15, 0, 1'b0, 1));
        wr(8'h24, 32'd0);
        start_measure(3000, cyc); chk("R5 clamp", 32'(cyc), 32'd1025);
        halt_and_clear();

        // R3 stop holds, start clears prescaler phase
        wr(8'h00, ctrl_word(2, 0, 1'b0, 1));
        wr(8'h24, 32'd5);
        wr(8'h04, 32'h1);
        wr(8'h04, 32'h2);
        rd(8'h24, v); chk("R3 stop holds", v, 32'd5);
        start_measure(200, cyc); chk("R3 phase reset", 32'(cyc), 32'd25);
        halt_and_clear();

        // R8 one-shot halts after reload
        wr(8'h1c, 32'h20);
        wr(8'h00, ctrl_word(0, 0, 1'b1, 1));
        wr(8'h24, 32'd3);
        start_measure(100, cyc); chk("R8 oneshot period", 32'(cyc), 32'd5);
        rd(8'h24, v);
        repeat (10) @(negedge clk);
        rd(8'h24, v2);
        chk("R8 reloaded", v, 32'h20);
        chk("R8 halted", v2, 32'h20);
        halt_and_clear();

        // R7 up mode overflow
        wr(8'h0c, 32'h1);
        wr(8'h1c, 32'd7);
        wr(8'h00, ctrl_word(0, 0, 1'b0, 0));
        wr(8'h24, 32'd0);
        start_measure(100, cyc); chk("R7 up period", 32'(cyc), 32'd9);
        wr(8'h04, 32'h2);
        rd(8'h10, v); chk("R7 overflow flag", v & 32'h3, 32'h1);

        // R10 masking and R9 set/clear aliases
        wr(8'h0c, 32'h0);
        chk("R10 masked", {31'b0, irq}, 32'h0);
        wr(8'h14, 32'h2);
        rd(8'h10, v); chk("R9 set alias", v, 32'h3);
        chk("R10 still masked", {31'b0, irq}, 32'h0);
        wr(8'h0c, 32'h2);
        chk("R10 enabled", {31'b0, irq}, 32'h1);
        wr(8'h18, 32'h2);
        chk("R10 cleared", {31'b0, irq}, 32'h0);
        rd(8'h10, v); chk("R9 clear alias", v, 32'h1);

        // R9 hardware set beats software clear in the same cycle
        wr(8'h0c, 32'h0);
        wr(8'h00, ctrl_word(0, 0, 1'b0, 1));
        wr(8'h1c, 32'h20);
        wr(8'h24, 32'd3);
        wr(8'h18, 32'h3);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h1;
        @(negedge clk); #1;
        bus_we = 1'b0; bus_addr = 8'h24; bus_wdata = '0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h2;
        @(negedge clk); #1;
        bus_we = 1'b0; bus_addr = 8'h24; bus_wdata = '0;
        wr(8'h04, 32'h2);
        rd(8'h10, v); chk("R9 hw set wins", v, 32'h2);
        wr(8'h18, 32'h3);

        // R4 load while running overrides the step
        wr(8'h24, 32'd100);
        wr(8'h04, 32'h1);
        wr(8'h24, 32'd50);
        rd(8'h24, v); chk("R4 load while running", v, 32'd48);
        wr(8'h04, 32'h2);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule